// File: doc/BRIEF.md
# Contended Memory Clock-Hold Generator

This block stretches a processor clock whenever the processor touches the memory bank that the display controller is also fetching from. It watches the two top address lines and a display-active flag to decide whether the current bus cycle collides with video fetches. The memory-request strobe then picks one of two hold windows. Each window is a range of positions of a three-bit fetch-slot counter that the video engine advances once per processor clock period. While the hold is active the processor clock is kept high, so the processor simply waits.

The block runs from a base clock at twice the processor clock rate. Every rising edge of the base clock is a transition of the processor clock. Both the incoming 3.5 MHz phase and the selected hold window are registered on that edge, so the hold can only start or end where the processor clock would change anyway. The address usually arrives before the memory strobe falls, which first selects the IO window. Because of the registering, that early selection can no longer chop a low phase short. The memory window is one slot shorter than the IO window, which makes up for the half-period added by the register.

Top module: `contend_clk_hold`

## Requirements
- R1: A bus cycle is contended only when `a_top` equals 2'b01 and `disp_on` is 1. For any other address, or with the display off, `hold` stays 0 whatever `mreq_n` and `hpos` are.
- R2: For a contended cycle with `mreq_n` low, the edge that samples it sets `hold` to 1 when `hpos` is 0 to 4 (`MEM_SPAN` = 5) and to 0 when `hpos` is 5 to 7.
- R3: For a contended cycle with `mreq_n` high, the edge that samples it sets `hold` to 1 when `hpos` is 0 to 5 (`IO_SPAN` = 6) and to 0 when `hpos` is 6 or 7.
- R4: `hold` changes only on a rising edge of `clk`, one edge after the inputs that select it. An input change between edges leaves `hold` as it was.
- R5: While `hold` is 1, `cpu_clk` is 1.
- R6: While `hold` is 0, `cpu_clk` equals the value of `clk35` sampled at the most recent rising edge of `clk`. This holds during reset too.
- R7: `rst` is synchronous and active high. A rising edge with `rst` at 1 sets `hold` to 0, and `cpu_clk` keeps following `clk35`.
- R8: No low phase of `cpu_clk` is shorter than one period of `clk`, which is half a period of the 3.5 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock at twice the processor clock rate; each rising edge is a processor clock transition |
| rst | input | 1 | Synchronous active-high reset of the hold register |
| clk35 | input | 1 | Stable 3.5 MHz processor clock phase, toggling once per `clk` period |
| a_top | input | 2 | Address bits 15 and 14 |
| mreq_n | input | 1 | Memory-request strobe, active low; selects the memory window when low, the IO window when high |
| disp_on | input | 1 | High while the display area is being drawn |
| hpos | input | 3 | Fetch-slot position, advanced once per processor clock period |
| cpu_clk | output | 1 | Processor clock: registered `clk35` forced high by the hold |
| hold | output | 1 | Registered clock-hold request |

## Verification
The assertions assume that every input is synchronous to `clk` and settles well before its rising edge. They also assume that `clk35` inverts once per `clk` period and that `hpos` steps once per full processor period. The timing claims about `hold` and `cpu_clk` rest on those assumptions. The bench changes all inputs only at the falling edge of `clk`. It toggles `clk35` at every such step and advances `hpos` each time `clk35` goes high. The memory strobe falls half a period after the address becomes valid, which recreates the early-address case in which the IO window is selected first.

// File: rtl/contend_clk_hold.sv
module contend_clk_hold #(
  parameter int         POS_W     = 3,
  parameter int         MEM_SPAN  = 5,
  parameter int         IO_SPAN   = 6,
  parameter logic [1:0] CONT_BANK = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk35,
  input  logic [1:0]       a_top,
  input  logic             mreq_n,
  input  logic             disp_on,
  input  logic [POS_W-1:0] hpos,
  output logic             cpu_clk,
  output logic             hold
);
  localparam logic [POS_W:0] MEM_LIM = MEM_SPAN[POS_W:0];
  localparam logic [POS_W:0] IO_LIM  = IO_SPAN[POS_W:0];

  logic ph_q, hold_q;

  wire in_bank = (a_top == CONT_BANK) & disp_on;
  wire mem_win = {1'b0, hpos} < MEM_LIM;
  wire io_win  = {1'b0, hpos} < IO_LIM;
  wire want    = in_bank & (mreq_n ? io_win : mem_win);

  always_ff @(posedge clk) begin
    ph_q <= clk35;
    if (rst) hold_q <= 1'b0;
    else     hold_q <= want;
  end

  assign hold    = hold_q;
  assign cpu_clk = ph_q | hold_q;
endmodule

// File: rtl/contend_clk_hold_chk.sv
module contend_clk_hold_chk #(
  parameter int         POS_W     = 3,
  parameter int         MEM_SPAN  = 5,
  parameter int         IO_SPAN   = 6,
  parameter logic [1:0] CONT_BANK = 2'b01
) (
  input logic             clk,
  input logic             rst,
  input logic             clk35,
  input logic [1:0]       a_top,
  input logic             mreq_n,
  input logic             disp_on,
  input logic [POS_W-1:0] hpos,
  input logic             cpu_clk,
  input logic             hold
);
  localparam logic [POS_W:0] MEM_LIM = MEM_SPAN[POS_W:0];
  localparam logic [POS_W:0] IO_LIM  = IO_SPAN[POS_W:0];

  logic in_bank;
  assign in_bank = (a_top == CONT_BANK) && disp_on;

  AST_HOLD_ONLY_CONTENDED: assert property (@(posedge clk) disable iff (rst)
    hold |-> $past(in_bank)); // R1
  AST_MEM_WINDOW_ON: assert property (@(posedge clk) disable iff (rst)
    (in_bank && !mreq_n && ({1'b0, hpos} < MEM_LIM)) |=> hold); // R2
  AST_MEM_WINDOW_OFF: assert property (@(posedge clk) disable iff (rst)
    (in_bank && !mreq_n && ({1'b0, hpos} >= MEM_LIM)) |=> !hold); // R2
  AST_IO_WINDOW_ON: assert property (@(posedge clk) disable iff (rst)
    (in_bank && mreq_n && ({1'b0, hpos} < IO_LIM)) |=> hold); // R3
  AST_IO_WINDOW_OFF: assert property (@(posedge clk) disable iff (rst)
    (in_bank && mreq_n && ({1'b0, hpos} >= IO_LIM)) |=> !hold); // R3
  AST_PHASE_PASS: assert property (@(posedge clk) disable iff (rst)
    !hold |-> (cpu_clk == $past(clk35))); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !hold); // R7
endmodule

bind contend_clk_hold contend_clk_hold_chk #(
  .POS_W(POS_W), .MEM_SPAN(MEM_SPAN), .IO_SPAN(IO_SPAN), .CONT_BANK(CONT_BANK)
) u_chk (
  .clk(clk), .rst(rst), .clk35(clk35), .a_top(a_top), .mreq_n(mreq_n),
  .disp_on(disp_on), .hpos(hpos), .cpu_clk(cpu_clk), .hold(hold)
);

// File: tb/tb_contend_clk_hold.sv
`timescale 1ns/1ps
module tb_contend_clk_hold;
  localparam int CLK_P = 142;

  logic clk = 1'b0, rst = 1'b1, clk35 = 1'b0, mreq_n = 1'b1, disp_on = 1'b0;
  logic [1:0] a_top = 2'b00;
  logic [2:0] hpos = 3'd0;
  wire cpu_clk, hold;

  contend_clk_hold dut (
    .clk(clk), .rst(rst), .clk35(clk35), .a_top(a_top), .mreq_n(mreq_n),
    .disp_on(disp_on), .hpos(hpos), .cpu_clk(cpu_clk), .hold(hold)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0, armed = 1'b0, p_valid = 1'b0;
  logic p_rst = 1'b1, p_clk35 = 1'b0, p_mreq = 1'b1, p_disp = 1'b0;
  logic [1:0] p_a = 2'b00;
  logic [2:0] p_hpos = 3'd0;
  realtime t_fall = 0;

  function automatic logic exp_hold(logic r, logic [1:0] a, logic d, logic m, logic [2:0] h);
    if (r) return 1'b0;
    if (!(a == 2'b01 && d)) return 1'b0;
    return m ? (h < 3'd6) : (h < 3'd5);
  endfunction

  task automatic chk(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(logic n_rst, logic [1:0] n_a, logic n_mreq, logic n_disp);
    logic eh;
    string tag;
    @(negedge clk);
    eh = exp_hold(p_rst, p_a, p_disp, p_mreq, p_hpos);
    if (p_valid) begin
      tag = p_rst ? "R7" : (!(p_a == 2'b01 && p_disp)) ? "R1" : p_mreq ? "R3" : "R2";
      chk(tag, hold, eh);
      chk(eh ? "R5" : "R6", cpu_clk, p_clk35 | eh);
    end
    clk35 = ~clk35;
    if (clk35) hpos = hpos + 3'd1;
    rst = n_rst; a_top = n_a; mreq_n = n_mreq; disp_on = n_disp;
    if (p_valid) begin
      #1;
      chk("R4", hold, eh);
    end
    p_rst = rst; p_clk35 = clk35; p_a = a_top; p_mreq = mreq_n;
    p_disp = disp_on; p_hpos = hpos; p_valid = 1'b1;
  endtask

  // R8: measure every low phase of the processor clock
  always @(negedge cpu_clk) t_fall = $realtime;
  always @(posedge cpu_clk) if (armed) begin
    checks++;
    if ($realtime - t_fall < CLK_P - 0.5) begin
      fails++;
      $display("FAIL R8 low phase actual=%0.1f expected>=%0d", $realtime - t_fall, CLK_P);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  task automatic access(logic [1:0] a, int len);
    step(1'b0, a, 1'b1, 1'b1);
    for (int i = 0; i < len; i++) step(1'b0, a, 1'b0, 1'b1);
    step(1'b0, 2'b00, 1'b1, 1'b1);
  endtask

  initial begin
    logic [1:0] ra;
    logic rm, rd, rr;
    void'($urandom(32'd20070916));
    // R7 / R6: reset with a contended request present, clock keeps running
    for (int i = 0; i < 6; i++) step(1'b1, 2'b01, 1'b0, 1'b1);
    step(1'b0, 2'b00, 1'b1, 1'b1);
    step(1'b0, 2'b00, 1'b1, 1'b1);
    armed = 1'b1;
    // R2: memory window across every slot position
    for (int i = 0; i < 32; i++) step(1'b0, 2'b01, 1'b0, 1'b1);
    // R3: IO window across every slot position
    for (int i = 0; i < 32; i++) step(1'b0, 2'b01, 1'b1, 1'b1);
    // R1: other banks and display off
    for (int b = 0; b < 4; b++)
      if (b != 1) for (int i = 0; i < 16; i++) step(1'b0, 2'(b), i[0], 1'b1);
    for (int i = 0; i < 16; i++) step(1'b0, 2'b01, i[1], 1'b0);
    // early address, late strobe (R8 corner)
    for (int k = 0; k < 8; k++) access(2'b01, 3 + k);
    // R7: reset in the middle of a hold
    step(1'b0, 2'b01, 1'b0, 1'b1);
    step(1'b0, 2'b01, 1'b0, 1'b1);
    step(1'b1, 2'b01, 1'b0, 1'b1);
    step(1'b1, 2'b01, 1'b0, 1'b1);
    step(1'b0, 2'b01, 1'b0, 1'b1);
    // constrained random mix
    rm = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      ra = ($urandom % 4 < 2) ? 2'b01 : 2'($urandom);
      rd = ($urandom % 4) != 0;
      if ($urandom % 10 < 3) rm = ~rm;
      rr = ($urandom % 100) == 0;
      step(rr, ra, rm, rd);
    end
    step(1'b0, 2'b00, 1'b1, 1'b0);
    finish_run();
  end
endmodule